// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block produces the command stream that brings freshly powered SDRAM devices into a usable state. Each channel runs the same fixed sequence. It issues one precharge-all command, then waits a programmed number of cycles. It then issues a programmed number of auto-refresh commands, and each refresh is followed by a programmed idle gap. Every cycle that carries neither command drives a deselect. The command for each channel leaves the block as a 2-bit code on every clock.

Software reaches the block through a small register port with two word addresses. Address 0 holds the timing parameters that all channels share. Address 1 is the control word. Writing a 1 to a channel's bit starts that channel. The same bit reads back as 1 for as long as the channel is running and returns to 0 by itself when the sequence has ended. A separate global bit in the control word starts every channel in the same cycle. The sequence is meant to run once on every channel after reset, and again on a single channel after that channel returns from deep power-down.

Top module: `sdinit_seq`

## Requirements
- R1: A start accepted at a clock edge makes the channel's busy flag high and its command precharge-all (01) in the cycle that follows that edge.
- R2: After the precharge-all, exactly P deselect cycles pass before the first auto-refresh, where P is timing-word bits [2:0] (0 to 7).
- R3: The channel issues N auto-refresh commands (code 10), where N is timing-word bits [11:8]. A field value of 0 behaves as 1, so 15 is the largest count.
- R4: Each auto-refresh is followed by exactly G deselect cycles, where G is timing-word bits [7:4]; this includes the last refresh.
- R5: The command code is 00 (deselect) on every cycle that carries no precharge-all or auto-refresh, and the code 11 never appears.
- R6: Control-word bit i and busy_o[i] read 1 from the first command cycle until the last gap after the final refresh has elapsed, and read 0 afterwards.
- R7: Writing control-word bit 15 as 1 starts every idle channel in the same cycle.
- R8: A start request for a channel that is already busy is ignored, and the running sequence keeps its length and its commands.
- R9: A write to the timing word while any channel is busy is ignored.
- R10: After reset every command is deselect, every busy flag is 0, and the timing word reads 0.
- R11: The timing word reads back at address 0 with P in [2:0], G in [7:4], N in [11:8] and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 timing word, 1 control word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 timing word, 1 control word |
| rd_data | output | 32 | Read data (combinational) |
| cmd_o | output | 2*NCH | Per-channel command code, channel i in bits [2i+1:2i] |
| busy_o | output | NCH | Per-channel busy flag |

## Verification
The bench targets the edges of the timing counters. It uses a zero precharge wait together with a zero gap, the maximum wait and gap with fifteen refreshes, and a refresh count of zero. A counter that is off by one would lengthen or shorten the stream by a cycle, and a design that took the zero count literally would issue no refresh at all. A second start sent mid-sequence and a timing write sent while a channel is busy are both checked. A design that restarted the channel would send a second precharge-all, and one that accepted the write would change a running sequence. The global start is checked on both channels at once, so a channel that lagged by a cycle or stayed idle would show up in the command stream.

// File: rtl/sdinit_pkg.sv
`timescale 1ns/1ps
package sdinit_pkg;
    localparam int PWAIT_W = 3;
    localparam int GAP_W   = 4;
    localparam int COUNT_W = 4;
    localparam int REG_W   = 32;
    localparam int GLOBAL_BIT = 15;

    typedef enum logic [1:0] {
        CMD_DSL = 2'b00,
        CMD_PRA = 2'b01,
        CMD_RFA = 2'b10
    } cmd_e;

    typedef struct packed {
        logic [COUNT_W-1:0] count;
        logic [GAP_W-1:0]   gap;
        logic [PWAIT_W-1:0] pwait;
    } timing_t;
endpackage

// File: rtl/sdinit_regs.sv
`timescale 1ns/1ps
module sdinit_regs
    import sdinit_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    input  logic [NCH-1:0]   busy_i,
    output timing_t          cfg_o,
    output logic [NCH-1:0]   start_o,
    output logic [REG_W-1:0] rd_data
);
    typedef struct packed {
        timing_t cfg;
    } regs_t;

    regs_t r_q, r_d;
    logic  any_busy;
    logic  ctrl_wr;

    assign any_busy = |busy_i;
    assign ctrl_wr  = wr_en && wr_addr;

    always_comb begin
        r_d = r_q;
        if (wr_en && !wr_addr && !any_busy) begin
            r_d.cfg.pwait = wr_data[PWAIT_W-1:0];
            r_d.cfg.gap   = wr_data[4 +: GAP_W];
            r_d.cfg.count = wr_data[8 +: COUNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++)
            start_o[i] = ctrl_wr && (wr_data[i] || wr_data[GLOBAL_BIT]);
    end

    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data[PWAIT_W-1:0]  = r_q.cfg.pwait;
            rd_data[4 +: GAP_W]   = r_q.cfg.gap;
            rd_data[8 +: COUNT_W] = r_q.cfg.count;
        end else begin
            rd_data[NCH-1:0] = busy_i;
        end
    end

    assign cfg_o = r_q.cfg;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && any_busy) |=> $stable(cfg_o)); // R9
endmodule

// File: rtl/sdinit_chan.sv
`timescale 1ns/1ps
module sdinit_chan
    import sdinit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  timing_t    cfg_i,
    output logic [1:0] cmd_o,
    output logic       busy_o
);
    localparam int CNT_W = (GAP_W > PWAIT_W) ? GAP_W : PWAIT_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRA, ST_PWAIT, ST_REF, ST_GAP
    } st_e;

    typedef struct packed {
        st_e                st;
        logic [CNT_W-1:0]   cnt;
        logic [COUNT_W-1:0] left;
    } chan_t;

    chan_t c_q, c_d;
    logic [COUNT_W-1:0] n_eff;

    assign n_eff = (cfg_i.count == '0) ? COUNT_W'(1) : cfg_i.count;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) c_d.st = ST_PRA;
            end
            ST_PRA: begin
                c_d.left = n_eff;
                if (cfg_i.pwait == '0) begin
                    c_d.st = ST_REF;
                end else begin
                    c_d.st  = ST_PWAIT;
                    c_d.cnt = CNT_W'(cfg_i.pwait);
                end
            end
            ST_PWAIT: begin
                c_d.cnt = c_q.cnt - CNT_W'(1);
                if (c_q.cnt == CNT_W'(1)) c_d.st = ST_REF;
            end
            ST_REF: begin
                c_d.left = c_q.left - COUNT_W'(1);
                if (cfg_i.gap == '0) begin
                    c_d.st = (c_q.left == COUNT_W'(1)) ? ST_IDLE : ST_REF;
                end else begin
                    c_d.st  = ST_GAP;
                    c_d.cnt = CNT_W'(cfg_i.gap);
                end
            end
            ST_GAP: begin
                c_d.cnt = c_q.cnt - CNT_W'(1);
                if (c_q.cnt == CNT_W'(1))
                    c_d.st = (c_q.left == '0) ? ST_IDLE : ST_REF;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cnt: '0, left: '0};
        else        c_q <= c_d;
    end

    always_comb begin
        case (c_q.st)
            ST_PRA:  cmd_o = CMD_PRA;
            ST_REF:  cmd_o = CMD_RFA;
            default: cmd_o = CMD_DSL;
        endcase
    end
    assign busy_o = (c_q.st != ST_IDLE);

    AST_PRA_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> cmd_o == CMD_PRA); // R1
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> cmd_o != CMD_PRA); // R8
    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != 2'b11); // R5
    AST_REFRESH_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(cmd_o) != CMD_PRA); // R3
endmodule

// File: rtl/sdinit_seq.sv
`timescale 1ns/1ps
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             rd_addr,
    output logic [31:0]      rd_data,
    output logic [2*NCH-1:0] cmd_o,
    output logic [NCH-1:0]   busy_o
);
    timing_t        cfg;
    logic [NCH-1:0] start;

    sdinit_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .busy_i  (busy_o),
        .cfg_o   (cfg),
        .start_o (start),
        .rd_data (rd_data)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        sdinit_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start[i]),
            .cfg_i   (cfg),
            .cmd_o   (cmd_o[2*i +: 2]),
            .busy_o  (busy_o[i])
        );
    end

    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && wr_data[GLOBAL_BIT] && busy_o == '0) |=> &busy_o); // R7
endmodule

// File: tb/sdinit_seq_test.sv
`timescale 1ns/1ps
module sdinit_seq_test;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic [2*NCH-1:0] cmd_o;
    logic [NCH-1:0] busy_o;

    int checks = 0;
    int errors = 0;
    logic mon_en = 1'b0;
    string tag = "R10";
    int cyc = 0;

    logic [2:0] expq [NCH][$];
    logic [2:0] pm = 3'd0;
    logic [3:0] gm = 4'd0;
    logic [3:0] nm = 4'd0;

    always #2 clk = ~clk;

    sdinit_seq #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_o(cmd_o), .busy_o(busy_o)
    );

    function automatic logic [31:0] tword(int p, int g, int n);
        return {20'd0, 4'(n), 4'(g), 1'b0, 3'(p)};
    endfunction

    // Monitor: pops the expected {cmd,busy} of each channel every cycle.
    always @(negedge clk) begin
        if (mon_en) begin
            for (int c = 0; c < NCH; c++) begin
                logic [2:0] e;
                logic [2:0] a;
                e = (expq[c].size() != 0) ? expq[c].pop_front() : 3'b000;
                a = {cmd_o[2*c +: 2], busy_o[c]};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s ch%0d cycle %0d: {cmd,busy} got %b exp %b", tag, c, cyc, a, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R6 watchdog: got busy %b exp idle", busy_o);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic a, input logic [31:0] d);
        logic [NCH-1:0] was_busy;
        logic [2:0] seq[$];
        @(posedge clk); #1;
        for (int c = 0; c < NCH; c++) was_busy[c] = (expq[c].size() != 0);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        seq.push_back({2'b01, 1'b1});
        for (int k = 0; k < pm; k++) seq.push_back({2'b00, 1'b1});
        for (int r = 0; r < ((nm == 0) ? 1 : nm); r++) begin
            seq.push_back({2'b10, 1'b1});
            for (int k = 0; k < gm; k++) seq.push_back({2'b00, 1'b1});
        end
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
        if (a) begin
            for (int c = 0; c < NCH; c++)
                if ((d[c] || d[15]) && !was_busy[c])
                    foreach (seq[k]) expq[c].push_back(seq[k]);
        end else if (was_busy == '0) begin
            pm = d[2:0]; gm = d[7:4]; nm = d[11:8];
        end
    endtask

    task automatic rd_chk(input logic a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        rd_addr = a;
        #0.5;
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s read addr %0d: got %h exp %h", t, a, rd_data, e);
        end
    endtask

    task automatic wait_idle();
        while (expq[0].size() != 0 || expq[1].size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state
        rd_chk(1'b0, 32'd0, "R10 timing");
        rd_chk(1'b1, 32'd0, "R10 control");
        mon_en = 1'b1;
        repeat (2) @(posedge clk);

        // R11 readback, then R1 R2 R3 R4 R5 R6 on channel 0
        tag = "R1 R2 R3 R4 R5";
        wr(1'b0, tword(2, 1, 3));
        rd_chk(1'b0, tword(2, 1, 3), "R11");
        wr(1'b1, 32'h1);
        rd_chk(1'b1, 32'h1, "R6 busy readback");
        wait_idle();
        rd_chk(1'b1, 32'h0, "R6 self-clear");

        // R3 zero count treated as one, with zero wait and zero gap on channel 1
        tag = "R3 R2 R4 zero fields";
        wr(1'b0, tword(0, 0, 0));
        wr(1'b1, 32'h2);
        wait_idle();

        // Maximum fields: P=7 G=15 N=15
        tag = "R2 R3 R4 max fields";
        wr(1'b0, tword(7, 15, 15));
        rd_chk(1'b0, tword(7, 15, 15), "R11 max");
        wr(1'b1, 32'h1);
        wait_idle();

        // R7 global start on all channels
        tag = "R7 global start";
        wr(1'b0, tword(1, 2, 2));
        wr(1'b1, 32'h8000);
        rd_chk(1'b1, 32'h3, "R7 both busy");
        wait_idle();

        // R8 restart request on a busy channel
        tag = "R8 busy restart";
        wr(1'b1, 32'h1);
        repeat (2) @(posedge clk);
        wr(1'b1, 32'h1);
        wait_idle();

        // R9 timing write while busy is dropped
        tag = "R9 timing locked";
        wr(1'b1, 32'h2);
        wr(1'b0, tword(5, 5, 5));
        rd_chk(1'b0, tword(1, 2, 2), "R9");
        wait_idle();
        rd_chk(1'b0, tword(1, 2, 2), "R9 after");

        mon_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule